// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a chain of boundary-scan cells that sits between a device's pins and its core logic. Each cell has a shift stage and a parallel output latch. The block is clocked by the test clock, and an outside test-access controller drives three strobes: capture, shift and update. Data moves serially from the test data input to a test data output that changes on the falling clock edge. The strobes reach the block already gated, so they are active only when this chain is the selected data register.

The block has three groups of cells. There is one cell per input pin, one per output pin value and one per output pin enable. In normal mode, all signals pass straight through between pins and core. An update still loads the output latch, but the loaded value has no effect until a test instruction is selected, so it acts as a preload. In test mode, the latch drives the output pins and the core-side inputs directly. A separate hold input lets the latch keep driving the pins while the core still sees the real pin inputs. This clamps the outputs while another data register is being shifted.

Top module: `bscan_chain`

## Requirements
- R1: A synchronous active-high reset clears every shift stage, every output latch and the serial output to 0. With test mode selected after a reset, all pin enables therefore read 0.
- R2: With test_mode=0 and hold_pins=0, the block passes signals through unchanged: pin_out=core_out, pin_oe=core_oe and core_in=pin_in, whatever the chain holds.
- R3: Chain position 0 is nearest the serial output. On a capture strobe, positions 0..N_IN-1 load pin_in, positions N_IN..N_IN+N_OUT-1 load the pin_out value being driven, and positions N_IN+N_OUT..LEN-1 load the pin_oe value being driven. This applies in both modes.
- R4: On a shift strobe without capture, each position takes the value from the position above it, and position LEN-1 takes tdi. Capture has priority over shift.
- R5: tdo is registered on the falling edge of tck from chain position 0.
- R6: An update strobe copies the whole shift stage into the output latch. The latch changes on no other strobe.
- R7: With test_mode=1, pin_out and pin_oe follow the value and enable latches, and core_in follows the input latches. This holds from the rising edge that performs the update, with no further register.
- R8: A value loaded by update with test_mode=0 does not reach the pins or the core. It takes effect as soon as test_mode is raised, with no new update.
- R9: With test_mode=0 and hold_pins=1, pin_out and pin_oe follow the latches while core_in still equals pin_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| capture_dr | input | 1 | Capture strobe, already gated for this chain |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in, entering at position LEN-1 |
| test_mode | input | 1 | 1 = latches drive pins and core |
| hold_pins | input | 1 | 1 = latches keep driving the pins only |
| tdo | output | 1 | Serial data out, falling-edge registered |
| pin_in | input | N_IN | Values arriving from input pins |
| core_in | output | N_IN | Input values presented to the core |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pin_out | output | N_OUT | Values toward the output pads |
| pin_oe | output | N_OUT | Enables toward the output pads |

## Verification
A wrong shift stage shows up as a wrong bit on tdo. The error appears at the first falling edge after the bad bit reaches position 0, which is at most LEN shift cycles after it was captured or shifted in. A wrong output latch shows up immediately on pin_out, pin_oe or core_in whenever test or hold mode is active. In normal mode, a corrupted preload stays invisible until test_mode is raised. For that reason the bench switches modes without a new update, to expose the stored state.

// File: rtl/bscan_chain_pkg.sv
package bscan_chain_pkg;

  function automatic int chain_len(input int n_in, input int n_out);
    return n_in + 2 * n_out;
  endfunction

  function automatic int val_base(input int n_in);
    return n_in;
  endfunction

  function automatic int oe_base(input int n_in, input int n_out);
    return n_in + n_out;
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic ser_d,
  output logic ser_q,
  output logic lat_q
);

  // shift stage: capture wins over shift
  always_ff @(posedge tck) begin
    if (rst)           ser_q <= 1'b0;
    else if (cap_en)   ser_q <= cap_d;
    else if (shift_en) ser_q <= ser_d;
  end

  // parallel output latch: moves only on update
  always_ff @(posedge tck) begin
    if (rst)         lat_q <= 1'b0;
    else if (upd_en) lat_q <= ser_q;
  end

endmodule

// File: rtl/bscan_io_mux.sv
module bscan_io_mux #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             test_mode,
  input  logic             hold_pins,
  input  logic [N_IN-1:0]  in_lat,
  input  logic [N_OUT-1:0] val_lat,
  input  logic [N_OUT-1:0] oe_lat,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);

  logic pins_from_lat;
  assign pins_from_lat = test_mode | hold_pins;

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    assign core_in[k] = test_mode ? in_lat[k] : pin_in[k];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign pin_out[k] = pins_from_lat ? val_lat[k] : core_out[k];
    assign pin_oe[k]  = pins_from_lat ? oe_lat[k]  : core_oe[k];
  end

endmodule

// File: rtl/bscan_tdo_reg.sv
module bscan_tdo_reg (
  input  logic tck,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(negedge tck) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_chain_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  input  logic             test_mode,
  input  logic             hold_pins,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);

  localparam int LEN  = chain_len(N_IN, N_OUT);
  localparam int VB   = val_base(N_IN);
  localparam int OB   = oe_base(N_IN, N_OUT);

  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] ser_in;
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] lat_q;

  // capture sources: pins for input cells, driven pad values for output cells
  assign cap_vec[N_IN-1:0]      = pin_in;
  assign cap_vec[VB +: N_OUT]   = pin_out;
  assign cap_vec[OB +: N_OUT]   = pin_oe;

  // serial path toward position 0
  assign ser_in = {tdi, sr_q[LEN-1:1]};

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    bscan_cell u_cell (
      .tck      (tck),
      .rst      (rst),
      .cap_en   (capture_dr),
      .shift_en (shift_dr),
      .upd_en   (update_dr),
      .cap_d    (cap_vec[i]),
      .ser_d    (ser_in[i]),
      .ser_q    (sr_q[i]),
      .lat_q    (lat_q[i])
    );
  end

  bscan_io_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
    .test_mode (test_mode),
    .hold_pins (hold_pins),
    .in_lat    (lat_q[N_IN-1:0]),
    .val_lat   (lat_q[VB +: N_OUT]),
    .oe_lat    (lat_q[OB +: N_OUT]),
    .pin_in    (pin_in),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .core_in   (core_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  bscan_tdo_reg u_tdo (
    .tck (tck),
    .rst (rst),
    .d   (sr_q[0]),
    .q   (tdo)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int LEN   = N_IN + 2 * N_OUT
) (
  input logic             tck,
  input logic             rst,
  input logic             capture_dr,
  input logic             shift_dr,
  input logic             update_dr,
  input logic             tdi,
  input logic             test_mode,
  input logic             hold_pins,
  input logic             tdo,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] pin_out,
  input logic [N_OUT-1:0] pin_oe,
  input logic [N_OUT-1:0] core_oe,
  input logic [LEN-1:0]   sr_q,
  input logic [LEN-1:0]   lat_q
);

  p_passthru_r2: assert property (@(posedge tck) disable iff (rst)
    (!test_mode && !hold_pins) |-> (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

  p_shift_move_r4: assert property (@(posedge tck) disable iff (rst)
    (shift_dr && !capture_dr) |=> (sr_q[LEN-2:0] == $past(sr_q[LEN-1:1]) && sr_q[LEN-1] == $past(tdi)));

  p_tdo_src_r5: assert property (@(posedge tck) disable iff (rst)
    tdo == sr_q[0]);

  p_latch_load_r6: assert property (@(posedge tck) disable iff (rst)
    update_dr |=> lat_q == $past(sr_q));

  p_latch_still_r6: assert property (@(posedge tck) disable iff (rst)
    !update_dr |=> $stable(lat_q));

  p_test_drive_r7: assert property (@(posedge tck) disable iff (rst)
    test_mode |-> (pin_out == lat_q[N_IN +: N_OUT] && pin_oe == lat_q[N_IN+N_OUT +: N_OUT]
                   && core_in == lat_q[N_IN-1:0]));

  p_hold_r9: assert property (@(posedge tck) disable iff (rst)
    (hold_pins && !test_mode) |-> (pin_out == lat_q[N_IN +: N_OUT] && core_in == pin_in));

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .LEN(LEN)) u_chk (
  .tck(tck), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .tdi(tdi), .test_mode(test_mode), .hold_pins(hold_pins),
  .tdo(tdo), .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
  .pin_out(pin_out), .pin_oe(pin_oe), .core_oe(core_oe), .sr_q(sr_q), .lat_q(lat_q)
);

// File: tb/bscan_chain_tb_top.sv
module bscan_chain_tb_top;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + 2 * NO;

  logic clk = 0, rst = 1, cap = 0, sh = 0, upd = 0, tdi = 0, tm = 0, hold = 0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0, core_oe = '0;
  logic tdo;
  logic [NO-1:0] pin_out, pin_oe;
  logic [NI-1:0] core_in;

  always #10 clk = ~clk;  // 50 MHz

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) dut_i (
    .tck(clk), .rst(rst), .capture_dr(cap), .shift_dr(sh), .update_dr(upd),
    .tdi(tdi), .test_mode(tm), .hold_pins(hold), .tdo(tdo),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  bit msr[L];
  bit mlat[L];
  bit mtdo;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit e_pout(int k);
    return (tm | hold) ? mlat[NI+k] : core_out[k];
  endfunction
  function automatic bit e_poe(int k);
    return (tm | hold) ? mlat[NI+NO+k] : core_oe[k];
  endfunction
  function automatic bit e_cin(int k);
    return tm ? mlat[k] : pin_in[k];
  endfunction

  task automatic cmp_all();
    string rp, rc;
    int ep, eo, ec;
    rp = tm ? "R7" : (hold ? "R9" : "R2");
    rc = tm ? "R7" : "R2";
    ep = 0; eo = 0; ec = 0;
    for (int k = 0; k < NO; k++) begin
      ep |= int'(e_pout(k)) << k;
      eo |= int'(e_poe(k)) << k;
    end
    for (int k = 0; k < NI; k++) ec |= int'(e_cin(k)) << k;
    chk("R5", "tdo", int'(tdo), int'(mtdo));
    chk(rp, "pin_out", int'(pin_out), ep);
    chk(rp, "pin_oe", int'(pin_oe), eo);
    chk(rc, "core_in", int'(core_in), ec);
  endtask

  task automatic step(bit c, bit s, bit u, bit t);
    bit capv[L];
    bit old[L];
    cap = c; sh = s; upd = u; tdi = t;
    // R3 capture sources, from what is driven just before the edge
    for (int k = 0; k < NI; k++) capv[k] = pin_in[k];
    for (int k = 0; k < NO; k++) begin
      capv[NI+k]    = e_pout(k);
      capv[NI+NO+k] = e_poe(k);
    end
    @(posedge clk);
    #1;
    old = msr;
    if (rst) begin
      for (int i = 0; i < L; i++) begin msr[i] = 0; mlat[i] = 0; end
    end else begin
      if (c) msr = capv;
      else if (s) begin
        for (int i = 0; i < L-1; i++) msr[i] = old[i+1];
        msr[L-1] = t;  // R4
      end
      if (u) mlat = old;  // R6
    end
    @(negedge clk);
    #1;
    mtdo = msr[0];
    cmp_all();
  endtask

  task automatic shift_in(int n, int pattern);
    for (int i = 0; i < n; i++) step(0, 1, 0, pattern[i % 32]);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    step(0, 0, 0, 0);
    step(1, 1, 1, 1);
    rst = 0;
    // R1: cleared state is visible in test mode
    tm = 1;
    step(0, 0, 0, 0);
    chk("R1", "pin_oe after reset", int'(pin_oe), 0);
    chk("R1", "tdo after reset", int'(tdo), 0);
    tm = 0;
    // R2: pass-through with several patterns
    for (int i = 0; i < 6; i++) begin
      pin_in = NI'($urandom); core_out = NO'($urandom); core_oe = NO'($urandom);
      step(0, 0, 0, 0);
    end
    // R3: normal-mode capture, then shift out
    pin_in = 4'b1011; core_out = 3'b110; core_oe = 3'b011;
    step(1, 0, 0, 0);
    chk("R3", "first captured bit", int'(tdo), 1);
    shift_in(L, 32'h2D5);
    // R6/R8: preload in normal mode, no effect on pins
    step(0, 0, 1, 0);
    chk("R8", "pin_out during preload", int'(pin_out), int'(core_out));
    // R8: raise test mode without update
    tm = 1;
    step(0, 0, 0, 0);
    // R7: capture in test mode, shift new data, update applies at once
    pin_in = 4'b0110;
    step(1, 0, 0, 0);
    shift_in(L, 32'h1A7);
    step(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      pin_in = NI'($urandom); core_out = NO'($urandom);
      step(0, 0, 0, 0);
    end
    // R4: capture priority over shift
    step(1, 1, 0, 1);
    shift_in(5, 32'h15);
    // R9: hold outputs in normal mode
    tm = 0; hold = 1;
    for (int i = 0; i < 4; i++) begin
      pin_in = NI'($urandom); core_out = NO'($urandom); core_oe = NO'($urandom);
      step(0, 0, 0, 0);
    end
    shift_in(L, 32'h3C9);
    step(0, 1, 1, 1);
    hold = 0;
    step(0, 0, 0, 0);
    // R1: reset mid-run clears latches
    rst = 1;
    step(0, 0, 0, 0);
    rst = 0; tm = 1;
    step(0, 0, 0, 0);
    chk("R1", "pin_out after late reset", int'(pin_out), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule